// File: doc/BRIEF.md
# Sleep Interval Timer

This block is a free-running 15-bit up counter that advances once for every pulse of a 32 kHz clock enable. The enable is delivered in the system clock domain, after the low-speed oscillator has been chosen elsewhere. A two-bit select field picks one counter bit as the interval tap. Each time that bit falls from 1 to 0, the block can raise a periodic interrupt. The interrupt does not depend on the sleep state of the system, so software can also use the block as a general-purpose tick source.

Software writes to a watchdog-clear register. Every write to that register produces a one-cycle strobe toward the watchdog counter, which is outside this block. A write whose data byte is the clear key also resets this counter, so that software can line up the first interval with its own start-up code.

Several things hold the counter at zero or stop it:
- The block's asynchronous reset and three synchronous hardware-reset event inputs (power-on, external pin, watchdog) clear the counter.
- When the debugger holds the CPU halted, counting stops. This keeps breakpoints from turning into watchdog resets.

Top module: `sleep_interval_timer`

## Requirements
- R1: While `rst_n` is low, `irq_o` and `wdt_clr_o` are 0 and the counter is 0. After release, the first interval with `int_sel_i`=0 completes on the 64th tick.
- R2: The counter is 15 bits wide. It advances by one on each clock cycle in which `tick_i` is 1, the counter is not frozen, and no clear is requested.
- R3: `int_sel_i` selects the tap bit at position 5 + 3*sel. The values 0, 1, 2 and 3 give an interrupt once every 64, 512, 4096 and 32768 ticks counted from zero.
- R4: `irq_o` is a pulse exactly one system clock wide. It is high in the cycle after the clock edge that samples the tick on which the selected bit falls from 1 to 0.
- R5: While `int_en_i` is 0, no interrupt is produced, but the counter keeps advancing.
- R6: A write (`wdclr_wr_i`=1) with `wdclr_data_i` equal to 8'h38 clears the counter to zero at that clock edge.
- R7: Every write pulses `wdt_clr_o` high for exactly the following cycle, whatever the data. A write with any data other than 8'h38 leaves the counter unchanged.
- R8: While `dbg_mode_i` and `cpu_stop_i` are both 1, the counter holds its value and no interrupt is raised. Either signal alone does not stop counting.
- R9: A one-cycle pulse on `por_evt_i`, `xres_evt_i` or `wdr_evt_i` clears the counter to zero.
- R10: When a clear and a tick arrive in the same cycle, the clear wins. The counter becomes zero and no interrupt is produced for that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_i | input | 1 | One-cycle 32 kHz count enable |
| por_evt_i | input | 1 | Power-on reset event, clears the counter |
| xres_evt_i | input | 1 | External reset event, clears the counter |
| wdr_evt_i | input | 1 | Watchdog reset event, clears the counter |
| dbg_mode_i | input | 1 | Debugger attached qualifier |
| cpu_stop_i | input | 1 | CPU halted condition |
| wdclr_wr_i | input | 1 | Write strobe for the watchdog-clear register |
| wdclr_data_i | input | 8 | Write data for the watchdog-clear register |
| int_en_i | input | 1 | Interval interrupt enable |
| int_sel_i | input | 2 | Interval select |
| irq_o | output | 1 | Interval interrupt pulse |
| wdt_clr_o | output | 1 | Clear strobe toward the watchdog counter |

## Verification
Both results are registered, so each becomes visible one clock after the edge that samples its cause:
- `irq_o` rises in the cycle after the last tick of an interval.
- `wdt_clr_o` rises in the cycle after the write.

The bench drives inputs on falling edges and samples on the next falling edge. It then checks `irq_o` high in exactly that cycle and low in the one after. The counter itself is not a port, so every effect on it (clears, freezes, clear-versus-tick) is measured by counting the ticks until the next interrupt pulse and comparing that count with the interval the requirements predict.

// File: rtl/sit_pkg.sv
package sit_pkg;
  // Default geometry of the interval timer
  localparam int CNT_W     = 15;
  localparam int SEL_W     = 2;
  localparam int FIRST_TAP = 5;
  localparam int TAP_STEP  = 3;
  localparam int DATA_W    = 8;
  localparam logic [DATA_W-1:0] CLR_KEY = 8'h38;

  // Counter bit that acts as interval tap for a select value
  function automatic int tap_pos(input int sel, input int first, input int step);
    return first + sel * step;
  endfunction
endpackage

// File: rtl/sit_wr_decode.sv
module sit_wr_decode #(
  parameter int DATA_W = sit_pkg::DATA_W,
  parameter logic [DATA_W-1:0] CLR_KEY = sit_pkg::CLR_KEY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sw_clr,
  output logic              wdt_clr
);
  logic wdt_clr_d;

  // Counter clear acts at the same edge as the write
  always_comb begin
    sw_clr    = wr_stb && (wr_data == CLR_KEY);
    wdt_clr_d = wr_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_clr <= 1'b0;
    end else begin
      wdt_clr <= wdt_clr_d;
    end
  end
endmodule

// File: rtl/sit_counter.sv
module sit_counter #(
  parameter int CNT_W = sit_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Clear has priority over advance
  always_comb begin
    cnt_en = clr | adv;
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/sit_irq_gen.sv
module sit_irq_gen #(
  parameter int CNT_W     = sit_pkg::CNT_W,
  parameter int SEL_W     = sit_pkg::SEL_W,
  parameter int FIRST_TAP = sit_pkg::FIRST_TAP,
  parameter int TAP_STEP  = sit_pkg::TAP_STEP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             adv,
  input  logic             clr,
  input  logic             int_en,
  input  logic [SEL_W-1:0] int_sel,
  output logic             irq
);
  localparam int NSEL = 2 ** SEL_W;

  // wrap[i]: bits up to tap i are all ones, so the next advance drops the tap
  logic [NSEL-1:0] wrap;
  logic            irq_d;

  for (genvar i = 0; i < NSEL; i++) begin : g_tap
    localparam int TAP = sit_pkg::tap_pos(i, FIRST_TAP, TAP_STEP);
    assign wrap[i] = &cnt[TAP:0];
  end

  always_comb begin
    irq_d = int_en & adv & ~clr & wrap[int_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
    end
  end
endmodule

// File: rtl/sleep_interval_timer.sv
module sleep_interval_timer #(
  parameter int CNT_W     = sit_pkg::CNT_W,
  parameter int SEL_W     = sit_pkg::SEL_W,
  parameter int FIRST_TAP = sit_pkg::FIRST_TAP,
  parameter int TAP_STEP  = sit_pkg::TAP_STEP,
  parameter int DATA_W    = sit_pkg::DATA_W,
  parameter logic [DATA_W-1:0] CLR_KEY = sit_pkg::CLR_KEY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              por_evt_i,
  input  logic              xres_evt_i,
  input  logic              wdr_evt_i,
  input  logic              dbg_mode_i,
  input  logic              cpu_stop_i,
  input  logic              wdclr_wr_i,
  input  logic [DATA_W-1:0] wdclr_data_i,
  input  logic              int_en_i,
  input  logic [SEL_W-1:0]  int_sel_i,
  output logic              irq_o,
  output logic              wdt_clr_o
);
  logic             run;
  logic             adv;
  logic             hw_clr;
  logic             sw_clr;
  logic             clr;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    run    = ~(dbg_mode_i & cpu_stop_i);
    adv    = tick_i & run;
    hw_clr = por_evt_i | xres_evt_i | wdr_evt_i;
    clr    = hw_clr | sw_clr;
  end

  sit_wr_decode #(.DATA_W(DATA_W), .CLR_KEY(CLR_KEY)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wdclr_wr_i),
    .wr_data (wdclr_data_i),
    .sw_clr  (sw_clr),
    .wdt_clr (wdt_clr_o)
  );

  sit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .clr   (clr),
    .cnt   (cnt_q)
  );

  sit_irq_gen #(
    .CNT_W(CNT_W), .SEL_W(SEL_W), .FIRST_TAP(FIRST_TAP), .TAP_STEP(TAP_STEP)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt_q),
    .adv     (adv),
    .clr     (clr),
    .int_en  (int_en_i),
    .int_sel (int_sel_i),
    .irq     (irq_o)
  );
endmodule

// File: rtl/sit_checker.sv
module sit_checker #(
  parameter int CNT_W  = sit_pkg::CNT_W,
  parameter int DATA_W = sit_pkg::DATA_W,
  parameter logic [DATA_W-1:0] CLR_KEY = sit_pkg::CLR_KEY
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              hw_evt,
  input logic              dbg,
  input logic              stop,
  input logic              wr,
  input logic [DATA_W-1:0] data,
  input logic              int_en,
  input logic [CNT_W-1:0]  cnt,
  input logic              irq,
  input logic              wdt_clr
);
  logic key_wr;
  assign key_wr = wr && (data == CLR_KEY);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(dbg && stop) && !key_wr && !hw_evt) |=> cnt == $past(cnt) + 1'b1);

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(int_en));

  // R6
  key_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> cnt == '0);

  // R7
  wdt_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> wdt_clr);

  // R7
  wdt_only_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |-> $past(wr));

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg && stop && !key_wr && !hw_evt) |=> $stable(cnt));

  // R8
  freeze_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(!(dbg && stop)));

  // R9
  hw_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |=> cnt == '0);

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (key_wr || hw_evt)) |=> (cnt == '0 && !irq));
endmodule

bind sleep_interval_timer sit_checker #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .CLR_KEY(CLR_KEY)
) u_sit_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick_i),
  .hw_evt  (por_evt_i | xres_evt_i | wdr_evt_i),
  .dbg     (dbg_mode_i),
  .stop    (cpu_stop_i),
  .wr      (wdclr_wr_i),
  .data    (wdclr_data_i),
  .int_en  (int_en_i),
  .cnt     (cnt_q),
  .irq     (irq_o),
  .wdt_clr (wdt_clr_o)
);

// File: tb/tb_sleep_interval_timer.sv
module tb_sleep_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i, por_evt_i, xres_evt_i, wdr_evt_i;
  logic       dbg_mode_i, cpu_stop_i, wdclr_wr_i, int_en_i;
  logic [7:0] wdclr_data_i;
  logic [1:0] int_sel_i;
  logic       irq_o, wdt_clr_o;

  int checks = 0;
  int fails  = 0;
  int irq_pulses = 0;
  int irq_high   = 0;
  logic irq_prev = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sleep_interval_timer dut (.*);

  // Count interrupt pulses and high cycles away from the active edge
  always @(negedge clk) begin
    if (irq_o) irq_high++;
    if (irq_o && !irq_prev) irq_pulses++;
    irq_prev = irq_o;
  end

  typedef struct packed {
    logic [1:0]  sel;
    logic        en;
    logic [15:0] ticks;
    logic [3:0]  exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b1, 16'd64,    4'd1},
    '{2'd0, 1'b1, 16'd63,    4'd0},
    '{2'd0, 1'b1, 16'd128,   4'd2},
    '{2'd0, 1'b1, 16'd1000,  4'd15},
    '{2'd1, 1'b1, 16'd511,   4'd0},
    '{2'd1, 1'b1, 16'd512,   4'd1},
    '{2'd2, 1'b1, 16'd4095,  4'd0},
    '{2'd2, 1'b1, 16'd4096,  4'd1},
    '{2'd0, 1'b0, 16'd200,   4'd0},
    '{2'd3, 1'b1, 16'd32768, 4'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic zero_mon();
    irq_pulses = 0;
    irq_high   = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic write(input logic [7:0] d, input logic with_tick);
    wdclr_wr_i   = 1'b1;
    wdclr_data_i = d;
    tick_i       = with_tick;
    @(negedge clk);
    wdclr_wr_i = 1'b0;
    tick_i     = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    rst_n = 1'b1;
    {tick_i, por_evt_i, xres_evt_i, wdr_evt_i, dbg_mode_i, cpu_stop_i} = '0;
    wdclr_wr_i = 1'b0; wdclr_data_i = 8'h00;
    int_en_i = 1'b1; int_sel_i = 2'd0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset, ticks ignored
    check("R1 irq in reset", irq_o, 0);
    check("R1 wdt_clr in reset", wdt_clr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    zero_mon();
    ticks(63);
    check("R1 no irq after 63 ticks from reset", irq_pulses, 0);
    ticks(1);
    check("R1 irq on 64th tick from reset", irq_pulses, 1);

    // Vector table: R3 interval selects, R5 disable, R4 pulse width
    for (int v = 0; v < NVEC; v++) begin
      int_sel_i = VECS[v].sel;
      int_en_i  = VECS[v].en;
      write(8'h38, 1'b0);
      @(negedge clk);
      zero_mon();
      ticks(int'(VECS[v].ticks));
      check($sformatf("R3 vec%0d irq count", v), irq_pulses, int'(VECS[v].exp));
      check($sformatf("R4 vec%0d one-cycle pulses", v), irq_high, irq_pulses);
    end
    int_sel_i = 2'd0; int_en_i = 1'b1;

    // R4: exact cycle of the pulse
    write(8'h38, 1'b0);
    ticks(63);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    check("R4 irq high cycle after last tick", irq_o, 1);
    @(negedge clk);
    check("R4 irq low one cycle later", irq_o, 0);

    // R5: counter keeps running while disabled
    write(8'h38, 1'b0);
    int_en_i = 1'b0;
    ticks(40);
    int_en_i = 1'b1;
    zero_mon();
    ticks(24);
    check("R5 counter ran while disabled", irq_pulses, 1);

    // R7: strobe timing and non-key data
    write(8'h38, 1'b0);
    ticks(40);
    wdclr_wr_i = 1'b1; wdclr_data_i = 8'h55;
    @(negedge clk);
    wdclr_wr_i = 1'b0;
    check("R7 wdt_clr cycle after write", wdt_clr_o, 1);
    @(negedge clk);
    check("R7 wdt_clr one cycle only", wdt_clr_o, 0);
    zero_mon();
    ticks(24);
    check("R7 non-key write keeps count", irq_pulses, 1);

    // R6: key write clears the counter
    write(8'h38, 1'b0);
    ticks(40);
    write(8'h38, 1'b0);
    check("R6 key write also strobes wdt", wdt_clr_o, 1);
    zero_mon();
    ticks(24);
    check("R6 no irq after clear", irq_pulses, 0);
    ticks(40);
    check("R6 full interval after clear", irq_pulses, 1);

    // R8: freeze with both, not with either alone
    write(8'h38, 1'b0);
    ticks(32);
    dbg_mode_i = 1'b1; cpu_stop_i = 1'b1;
    zero_mon();
    ticks(100);
    check("R8 frozen no irq", irq_pulses, 0);
    dbg_mode_i = 1'b0; cpu_stop_i = 1'b0;
    ticks(31);
    check("R8 held value before resume", irq_pulses, 0);
    ticks(1);
    check("R8 resumes from held value", irq_pulses, 1);
    write(8'h38, 1'b0);
    dbg_mode_i = 1'b1;
    zero_mon();
    ticks(64);
    check("R8 debug alone counts", irq_pulses, 1);
    dbg_mode_i = 1'b0; cpu_stop_i = 1'b1;
    zero_mon();
    ticks(64);
    check("R8 stop alone counts", irq_pulses, 1);
    cpu_stop_i = 1'b0;

    // R9: each hardware event clears the counter
    for (int s = 0; s < 3; s++) begin
      write(8'h38, 1'b0);
      ticks(40);
      por_evt_i = (s == 0); xres_evt_i = (s == 1); wdr_evt_i = (s == 2);
      @(negedge clk);
      {por_evt_i, xres_evt_i, wdr_evt_i} = '0;
      zero_mon();
      ticks(63);
      check($sformatf("R9 source%0d cleared", s), irq_pulses, 0);
      ticks(1);
      check($sformatf("R9 source%0d full interval", s), irq_pulses, 1);
    end

    // R10: clear and tick together
    write(8'h38, 1'b0);
    ticks(63);
    zero_mon();
    write(8'h38, 1'b1);
    @(negedge clk);
    check("R10 no irq on cleared tick", irq_pulses, 0);
    ticks(63);
    check("R10 counter restarted at zero", irq_pulses, 0);
    ticks(1);
    check("R10 interval after clear", irq_pulses, 1);

    report();
  end
endmodule